// File: doc/BRIEF.md
# Directory Home-Node Controller

This block is the home-node engine of a small distributed shared memory. For every memory block it owns, it records a coherence state (Uncached, Shared or Exclusive) and a sharer bit vector with one bit per processor. It holds the block data in a small internal array.

Caches send it read-miss, write-miss and write-back requests. The block answers each request in full before it takes the next one. It first sends any invalidates or owner fetches the request needs. It then waits for the owner's data on a separate response channel. Last, it sends the requester a data reply or an acknowledge.

Every channel uses valid/ready handshakes. All outgoing messages share one channel, with fields for type, target processor, address and data.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset, req_ready_o is high and out_valid_o and rsp_ready_o are low. Every block is Uncached and holds zero, so the first read miss to any address replies with data 0.
- R2: A read miss (req_type_i = 0) to an Uncached or Shared block produces exactly one data reply (out_type_o = 3). The reply goes to the requester, echoes the address and carries the stored value. The requester joins the sharer set and the block becomes Shared.
- R3: A write miss (req_type_i = 1) to an Uncached block produces a data reply carrying the stored value. The block becomes Exclusive with the requester as sole owner.
- R4: A read miss to a Shared block adds the requester and keeps every earlier sharer. This shows in the invalidates that a later write miss sends.
- R5: A write miss to a Shared block first sends one invalidate (out_type_o = 0, data 0) to each sharer other than the requester, in ascending processor id. It then sends the data reply with the stored value, and the requester becomes sole Exclusive owner. A requester that is the only sharer gets the reply with no invalidate.
- R6: A read miss to an Exclusive block sends a fetch (out_type_o = 1) to the owner, the lowest set sharer bit, and waits for the data on the response channel. It stores that data in memory and replies with it. The block becomes Shared, with both the old owner and the requester as sharers.
- R7: A write miss to an Exclusive block sends a fetch-and-invalidate (out_type_o = 2) to the owner. It forwards the returned data in the data reply, and the requester becomes sole Exclusive owner.
- R8: A write-back (req_type_i = 2) from the owner of an Exclusive block writes its data to memory and leaves the block Uncached with no sharers. A write-back from any other processor, or to a block that is not Exclusive, changes neither state nor memory. Either kind is answered with an acknowledge (out_type_o = 4, data 0).
- R9: Requests are handled one at a time. req_ready_o is low from acceptance until the last outgoing message of that request is accepted. rsp_ready_o is high only while owner data is awaited, and out_valid_o is low during that time.
- R10: The first outgoing message is valid in the cycle after the request is accepted. Each further message is valid in the cycle after the previous one is accepted. The reply is valid in the cycle after the owner data is accepted. A message is held stable while out_ready_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Controller idle and accepting a request |
| req_type_i | input | 2 | 0 read miss, 1 write miss, 2 write-back |
| req_pid_i | input | PID_W | Requesting processor id |
| req_addr_i | input | ADDR_W | Block address |
| req_data_i | input | DATA_W | Write-back data |
| rsp_valid_i | input | 1 | Owner data valid |
| rsp_ready_o | output | 1 | Controller awaiting owner data |
| rsp_data_i | input | DATA_W | Data returned by the owner |
| out_valid_o | output | 1 | Outgoing message valid |
| out_ready_i | input | 1 | Outgoing message accepted |
| out_type_o | output | 3 | 0 invalidate, 1 fetch, 2 fetch-and-invalidate, 3 data reply, 4 acknowledge |
| out_pid_o | output | PID_W | Target processor |
| out_addr_o | output | ADDR_W | Block address |
| out_data_o | output | DATA_W | Reply data, zero for every other type |

## Verification
Every result has a fixed latency, counted in edges:
- The first message is valid at the first falling edge after the accepting rising edge.
- Each later message is valid at the falling edge that follows the rising edge at which the previous one was taken.
- The reply is valid one edge after the owner data is taken.

The bench sweeps every address through a fixed sequence of requests that visits every state transition, with rotating processor ids. It keeps its own directory model and checks each message at exactly its due falling edge, with no polling loop. Where it withholds out_ready_i on the first message, it checks at each held edge that the message stays unchanged and that req_ready_o stays low.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [1:0] {
    REQ_RD = 2'd0,
    REQ_WR = 2'd1,
    REQ_WB = 2'd2
  } req_e;

  typedef enum logic [2:0] {
    MSG_INV       = 3'd0,
    MSG_FETCH     = 3'd1,
    MSG_FETCH_INV = 3'd2,
    MSG_DATA      = 3'd3,
    MSG_ACK       = 3'd4
  } msg_e;

  typedef enum logic [1:0] {
    BLK_UNC = 2'd0,
    BLK_SHR = 2'd1,
    BLK_EXC = 2'd2
  } blk_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_INV,
    PH_FETCH,
    PH_WAIT,
    PH_REPLY
  } phase_e;
endpackage

// File: rtl/dir_lowbit.sv
module dir_lowbit #(
  parameter int N = 4,
  parameter int W = 2
) (
  input  logic [N-1:0] vec_i,
  output logic [W-1:0] idx_o,
  output logic         any_o
);
  always_comb begin
    idx_o = '0;
    any_o = |vec_i;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = W'(i);
    end
  end
endmodule

// File: rtl/dir_store.sv
module dir_store #(
  parameter int NPROC  = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [1:0]        rd_state_o,
  output logic [NPROC-1:0]  rd_sharers_o,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              dir_we_i,
  input  logic [1:0]        wr_state_i,
  input  logic [NPROC-1:0]  wr_sharers_i,
  input  logic              mem_we_i,
  input  logic [DATA_W-1:0] wr_data_i
);
  import dir_pkg::*;
  localparam int NBLK = 1 << ADDR_W;

  logic [1:0]        st_arr [NBLK];
  logic [NPROC-1:0]  sh_arr [NBLK];
  logic [DATA_W-1:0] mem_arr[NBLK];

  for (genvar b = 0; b < NBLK; b++) begin : g_blk
    logic              hit;
    logic [1:0]        st_q;
    logic [NPROC-1:0]  sh_q;
    logic [DATA_W-1:0] mem_q;

    assign hit = (wr_addr_i == ADDR_W'(b));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q  <= BLK_UNC;
        sh_q  <= '0;
        mem_q <= '0;
      end else begin
        if (dir_we_i && hit) begin
          st_q <= wr_state_i;
          sh_q <= wr_sharers_i;
        end
        if (mem_we_i && hit) mem_q <= wr_data_i;
      end
    end

    assign st_arr[b]  = st_q;
    assign sh_arr[b]  = sh_q;
    assign mem_arr[b] = mem_q;
  end

  assign rd_state_o   = st_arr[rd_addr_i];
  assign rd_sharers_o = sh_arr[rd_addr_i];
  assign rd_data_o    = mem_arr[rd_addr_i];
endmodule

// File: rtl/dir_seq.sv
module dir_seq #(
  parameter int NPROC  = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int PID_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_type_i,
  input  logic [PID_W-1:0]  req_pid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_data_i,
  input  logic              rsp_valid_i,
  output logic              rsp_ready_o,
  input  logic [DATA_W-1:0] rsp_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [2:0]        out_type_o,
  output logic [PID_W-1:0]  out_pid_o,
  output logic [ADDR_W-1:0] out_addr_o,
  output logic [DATA_W-1:0] out_data_o,
  input  logic [1:0]        rd_state_i,
  input  logic [NPROC-1:0]  rd_sharers_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic              dir_we_o,
  output logic [1:0]        wr_state_o,
  output logic [NPROC-1:0]  wr_sharers_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] wr_data_o
);
  import dir_pkg::*;

  phase_e            phase_q;
  logic [1:0]        kind_q;
  logic [PID_W-1:0]  pid_q;
  logic [PID_W-1:0]  owner_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [NPROC-1:0]  inv_q;

  logic              accept;
  logic [NPROC-1:0]  req_bit;
  logic [PID_W-1:0]  own_idx;
  logic              own_any;
  logic [PID_W-1:0]  inv_idx;
  logic              inv_any;
  logic [NPROC-1:0]  inv_rest;
  logic [NPROC-1:0]  inv_init;
  logic              is_exc;
  logic              owner_wb;

  dir_lowbit #(.N(NPROC), .W(PID_W)) u_own (
    .vec_i(rd_sharers_i), .idx_o(own_idx), .any_o(own_any)
  );
  dir_lowbit #(.N(NPROC), .W(PID_W)) u_inv (
    .vec_i(inv_q), .idx_o(inv_idx), .any_o(inv_any)
  );

  assign accept   = (phase_q == PH_IDLE) && req_valid_i;
  assign req_bit  = NPROC'(1) << req_pid_i;
  assign is_exc   = (rd_state_i == BLK_EXC) && own_any;
  assign owner_wb = is_exc && (rd_sharers_i == req_bit);
  assign inv_init = (rd_state_i == BLK_SHR) ? (rd_sharers_i & ~req_bit) : '0;
  assign inv_rest = inv_q & ~(NPROC'(1) << inv_idx);

  // directory and memory writes
  always_comb begin
    dir_we_o     = 1'b0;
    mem_we_o     = 1'b0;
    wr_addr_o    = addr_q;
    wr_state_o   = rd_state_i;
    wr_sharers_o = rd_sharers_i;
    wr_data_o    = rsp_data_i;
    if (accept) begin
      wr_addr_o = req_addr_i;
      case (req_type_i)
        REQ_RD: begin
          dir_we_o     = 1'b1;
          wr_state_o   = BLK_SHR;
          wr_sharers_o = rd_sharers_i | req_bit;
        end
        REQ_WR: begin
          dir_we_o     = 1'b1;
          wr_state_o   = BLK_EXC;
          wr_sharers_o = req_bit;
        end
        default: begin
          if ((req_type_i == REQ_WB) && owner_wb) begin
            dir_we_o     = 1'b1;
            mem_we_o     = 1'b1;
            wr_state_o   = BLK_UNC;
            wr_sharers_o = '0;
            wr_data_o    = req_data_i;
          end
        end
      endcase
    end else if ((phase_q == PH_WAIT) && rsp_valid_i && (kind_q == REQ_RD)) begin
      mem_we_o = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      kind_q  <= '0;
      pid_q   <= '0;
      owner_q <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      inv_q   <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          if (req_valid_i) begin
            kind_q  <= req_type_i;
            pid_q   <= req_pid_i;
            addr_q  <= req_addr_i;
            owner_q <= own_idx;
            inv_q   <= '0;
            data_q  <= rd_data_i;
            case (req_type_i)
              REQ_RD: phase_q <= is_exc ? PH_FETCH : PH_REPLY;
              REQ_WR: begin
                if (is_exc) begin
                  phase_q <= PH_FETCH;
                end else begin
                  inv_q   <= inv_init;
                  phase_q <= (|inv_init) ? PH_INV : PH_REPLY;
                end
              end
              default: begin
                data_q  <= '0;
                phase_q <= PH_REPLY;
              end
            endcase
          end
        end
        PH_INV: begin
          if (out_ready_i) begin
            inv_q <= inv_rest;
            if (!(|inv_rest)) phase_q <= PH_REPLY;
          end
        end
        PH_FETCH: begin
          if (out_ready_i) phase_q <= PH_WAIT;
        end
        PH_WAIT: begin
          if (rsp_valid_i) begin
            data_q  <= rsp_data_i;
            phase_q <= PH_REPLY;
          end
        end
        PH_REPLY: begin
          if (out_ready_i) phase_q <= PH_IDLE;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  // outgoing message view
  always_comb begin
    out_valid_o = 1'b0;
    out_type_o  = MSG_DATA;
    out_pid_o   = pid_q;
    out_data_o  = '0;
    case (phase_q)
      PH_INV: begin
        out_valid_o = inv_any;
        out_type_o  = MSG_INV;
        out_pid_o   = inv_idx;
      end
      PH_FETCH: begin
        out_valid_o = 1'b1;
        out_type_o  = (kind_q == REQ_WR) ? MSG_FETCH_INV : MSG_FETCH;
        out_pid_o   = owner_q;
      end
      PH_REPLY: begin
        out_valid_o = 1'b1;
        out_type_o  = (kind_q == REQ_RD || kind_q == REQ_WR) ? MSG_DATA : MSG_ACK;
        out_data_o  = data_q;
      end
      default: ;
    endcase
  end

  assign out_addr_o  = addr_q;
  assign req_ready_o = (phase_q == PH_IDLE);
  assign rsp_ready_o = (phase_q == PH_WAIT);
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl #(
  parameter int NPROC  = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  localparam int PID_W = (NPROC > 1) ? $clog2(NPROC) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_type_i,
  input  logic [PID_W-1:0]  req_pid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_data_i,
  input  logic              rsp_valid_i,
  output logic              rsp_ready_o,
  input  logic [DATA_W-1:0] rsp_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [2:0]        out_type_o,
  output logic [PID_W-1:0]  out_pid_o,
  output logic [ADDR_W-1:0] out_addr_o,
  output logic [DATA_W-1:0] out_data_o
);
  logic [1:0]        rd_state;
  logic [NPROC-1:0]  rd_sharers;
  logic [DATA_W-1:0] rd_data;
  logic [ADDR_W-1:0] wr_addr;
  logic              dir_we;
  logic [1:0]        wr_state;
  logic [NPROC-1:0]  wr_sharers;
  logic              mem_we;
  logic [DATA_W-1:0] wr_data;

  dir_store #(.NPROC(NPROC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rd_addr_i    (req_addr_i),
    .rd_state_o   (rd_state),
    .rd_sharers_o (rd_sharers),
    .rd_data_o    (rd_data),
    .wr_addr_i    (wr_addr),
    .dir_we_i     (dir_we),
    .wr_state_i   (wr_state),
    .wr_sharers_i (wr_sharers),
    .mem_we_i     (mem_we),
    .wr_data_i    (wr_data)
  );

  dir_seq #(.NPROC(NPROC), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PID_W(PID_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_ready_o  (req_ready_o),
    .req_type_i   (req_type_i),
    .req_pid_i    (req_pid_i),
    .req_addr_i   (req_addr_i),
    .req_data_i   (req_data_i),
    .rsp_valid_i  (rsp_valid_i),
    .rsp_ready_o  (rsp_ready_o),
    .rsp_data_i   (rsp_data_i),
    .out_valid_o  (out_valid_o),
    .out_ready_i  (out_ready_i),
    .out_type_o   (out_type_o),
    .out_pid_o    (out_pid_o),
    .out_addr_o   (out_addr_o),
    .out_data_o   (out_data_o),
    .rd_state_i   (rd_state),
    .rd_sharers_i (rd_sharers),
    .rd_data_i    (rd_data),
    .wr_addr_o    (wr_addr),
    .dir_we_o     (dir_we),
    .wr_state_o   (wr_state),
    .wr_sharers_o (wr_sharers),
    .mem_we_o     (mem_we),
    .wr_data_o    (wr_data)
  );
endmodule

// File: rtl/dir_home_chk.sv
module dir_home_chk #(
  parameter int PID_W  = 2,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [PID_W-1:0]  req_pid_i,
  input logic              rsp_ready_o,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [2:0]        out_type_o,
  input logic [PID_W-1:0]  out_pid_o,
  input logic [ADDR_W-1:0] out_addr_o,
  input logic [DATA_W-1:0] out_data_o
);
  import dir_pkg::*;

  logic [PID_W-1:0] req_pid_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_pid_q <= '0;
    else if (req_valid_i && req_ready_o) req_pid_q <= req_pid_i;
  end

  p_out_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_type_o) &&
      $stable(out_pid_o) && $stable(out_addr_o) && $stable(out_data_o)));

  p_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o || rsp_ready_o) |-> !req_ready_o);

  p_wait_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_ready_o |-> !out_valid_o);

  p_inv_order_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && out_type_o == MSG_INV) |=>
      (!(out_valid_o && out_type_o == MSG_INV) || (out_pid_o > $past(out_pid_o))));

  p_inv_skip_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_type_o == MSG_INV) |-> (out_pid_o != req_pid_q));

  p_reply_pid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && (out_type_o == MSG_DATA || out_type_o == MSG_ACK)) |-> (out_pid_o == req_pid_q));

  p_fetch_wait_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && (out_type_o == MSG_FETCH || out_type_o == MSG_FETCH_INV))
      |=> rsp_ready_o);
endmodule

bind dir_home_ctrl dir_home_chk #(.PID_W(PID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_pid_i   (req_pid_i),
  .rsp_ready_o (rsp_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_type_o  (out_type_o),
  .out_pid_o   (out_pid_o),
  .out_addr_o  (out_addr_o),
  .out_data_o  (out_data_o)
);

// File: tb/sim_dir_home_ctrl.sv
module sim_dir_home_ctrl;
  import dir_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NPROC  = 4;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int NBLK   = 1 << ADDR_W;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid, req_ready;
  logic [1:0] req_type;
  logic [1:0] req_pid;
  logic [3:0] req_addr;
  logic [7:0] req_data;
  logic       rsp_valid, rsp_ready;
  logic [7:0] rsp_data;
  logic       out_valid, out_ready;
  logic [2:0] out_type;
  logic [1:0] out_pid;
  logic [3:0] out_addr;
  logic [7:0] out_data;

  int checks = 0;
  int errors = 0;
  int m_st [NBLK];
  int m_sh [NBLK];
  int m_mem[NBLK];
  int m_own[NBLK];

  always #(CLK_PERIOD / 2) clk = ~clk;

  dir_home_ctrl #(.NPROC(NPROC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_type_i(req_type),
    .req_pid_i(req_pid), .req_addr_i(req_addr), .req_data_i(req_data),
    .rsp_valid_i(rsp_valid), .rsp_ready_o(rsp_ready), .rsp_data_i(rsp_data),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_type_o(out_type),
    .out_pid_o(out_pid), .out_addr_o(out_addr), .out_data_o(out_data)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int pack_msg(int t, int p, int a, int d);
    return (t << 16) | (p << 12) | (a << 8) | d;
  endfunction

  function automatic int low_idx(int v);
    for (int i = NPROC - 1; i >= 0; i--) if (v[i]) low_idx = i;
  endfunction

  task automatic do_req(input int t, input int p, input int a, input int d,
                        input int stall, input string tag);
    int et[8];
    int ep[8];
    int ed[8];
    int n = 0;
    int fv = 0;
    int bitv = 1 << p;
    int own;
    int act;
    // expected messages from the reference model
    if (t == 0) begin
      if (m_st[a] == 2) begin
        own = low_idx(m_sh[a]);
        fv = m_own[a];
        et[n] = MSG_FETCH; ep[n] = own; ed[n] = 0; n++;
        m_mem[a] = fv;
        et[n] = MSG_DATA; ep[n] = p; ed[n] = fv; n++;
      end else begin
        et[n] = MSG_DATA; ep[n] = p; ed[n] = m_mem[a]; n++;
      end
      m_sh[a] = m_sh[a] | bitv;
      m_st[a] = 1;
    end else if (t == 1) begin
      if (m_st[a] == 2) begin
        own = low_idx(m_sh[a]);
        fv = m_own[a];
        et[n] = MSG_FETCH_INV; ep[n] = own; ed[n] = 0; n++;
        et[n] = MSG_DATA; ep[n] = p; ed[n] = fv; n++;
      end else begin
        if (m_st[a] == 1) begin
          for (int i = 0; i < NPROC; i++) begin
            if (m_sh[a][i] && i != p) begin
              et[n] = MSG_INV; ep[n] = i; ed[n] = 0; n++;
            end
          end
        end
        et[n] = MSG_DATA; ep[n] = p; ed[n] = m_mem[a]; n++;
      end
      m_sh[a] = bitv;
      m_st[a] = 2;
      m_own[a] = d;
    end else begin
      if (m_st[a] == 2 && m_sh[a] == bitv) begin
        m_mem[a] = d;
        m_st[a] = 0;
        m_sh[a] = 0;
      end
      et[n] = MSG_ACK; ep[n] = p; ed[n] = 0; n++;
    end

    req_valid = 1'b1;
    req_type  = 2'(t);
    req_pid   = 2'(p);
    req_addr  = 4'(a);
    req_data  = 8'(d);
    chk(req_ready == 1'b1, "R9", "ready before accept", int'(req_ready), 1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < n; i++) begin
      int s_max = (i == 0) ? stall : 0;
      for (int s = 0; s < s_max; s++) begin
        act = pack_msg(int'(out_type), int'(out_pid), int'(out_addr), int'(out_data));
        chk(out_valid && !req_ready, "R9", "busy while held", int'({out_valid, req_ready}), 2);
        chk(act == pack_msg(et[i], ep[i], a, ed[i]), "R10", "held message", act,
            pack_msg(et[i], ep[i], a, ed[i]));
        @(posedge clk);
        @(negedge clk);
      end
      out_ready = 1'b1;
      act = pack_msg(int'(out_type), int'(out_pid), int'(out_addr), int'(out_data));
      chk(out_valid && !req_ready, "R10", "message due", int'({out_valid, req_ready}), 2);
      chk(act == pack_msg(et[i], ep[i], a, ed[i]), tag, "message", act,
          pack_msg(et[i], ep[i], a, ed[i]));
      @(posedge clk);
      @(negedge clk);
      out_ready = 1'b0;
      if (et[i] == MSG_FETCH || et[i] == MSG_FETCH_INV) begin
        chk(!out_valid && rsp_ready, "R9", "awaiting owner data", int'({out_valid, rsp_ready}), 1);
        rsp_valid = 1'b1;
        rsp_data  = 8'(fv);
        @(posedge clk);
        @(negedge clk);
        rsp_valid = 1'b0;
      end
    end
    chk(req_ready && !out_valid && !rsp_ready, "R9", "idle after last message",
        int'({req_ready, out_valid, rsp_ready}), 4);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL R9 watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_type = '0; req_pid = '0; req_addr = '0; req_data = '0;
    rsp_valid = 1'b0; rsp_data = '0; out_ready = 1'b0;
    for (int b = 0; b < NBLK; b++) begin
      m_st[b] = 0; m_sh[b] = 0; m_mem[b] = 0; m_own[b] = 0;
    end
    repeat (3) @(negedge clk);
    chk(req_ready && !out_valid && !rsp_ready, "R1", "reset outputs",
        int'({req_ready, out_valid, rsp_ready}), 4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !out_valid && !rsp_ready, "R1", "after reset",
        int'({req_ready, out_valid, rsp_ready}), 4);

    for (int a = 0; a < NBLK; a++) begin
      int p0 = a % NPROC;
      int p1 = (a + 1) % NPROC;
      int p2 = (a + 2) % NPROC;
      int p3 = (a + 3) % NPROC;
      int st = (a % 3 == 0) ? 2 : 0;
      do_req(0, p0, a, 0,      st, "R1 R2");
      do_req(0, p1, a, 0,      0,  "R4");
      do_req(0, p2, a, 0,      st, "R4");
      do_req(1, p3, a, a + 16, st, "R4 R5");
      do_req(0, p1, a, 0,      st, "R6");
      do_req(1, p2, a, a + 32, 0,  "R5");
      do_req(1, p0, a, a + 48, st, "R7");
      do_req(2, p1, a, 99,     st, "R8");
      do_req(0, p1, a, 0,      0,  "R8");
      do_req(2, p3, a, 98,     0,  "R8");
      do_req(2, p1, a, a + 64, st, "R8");
      do_req(0, p3, a, 0,      0,  "R8");
      do_req(1, p3, a, a + 70, st, "R5");
      do_req(2, p3, a, a + 80, 0,  "R8");
      do_req(1, p1, a, a + 90, st, "R3");
      do_req(0, p1, a, 0,      0,  "R6");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule